// File: doc/BRIEF.md
# UART Host Register Bank with Receive Queue

This block is the byte-wide register front end of a 16550-style UART. A host reaches eight registers through a 3-bit offset, a write strobe and a read strobe. The bank holds the interrupt enable, line control, modem control, scratch and baud divisor registers. It drives the modem control pins and the transmit holding byte toward the serializer. It also hosts a receive queue that the receiver fills and that the host drains by reading offset 0.

Bit 7 of line control switches offsets 0 and 1 between the data path and the two divisor bytes. Offset 2 is split by direction. A write there is decoded into FIFO enable, DMA mode and a receive trigger level, plus one-cycle flush pulses. A read there returns the interrupt identification byte that a neighbouring interrupt block supplies. A receive-trigger output compares the queue fill against the selected level.

Top module: `uart_hostregs`

## Requirements
- R1: After reset, interrupt enable, line control, modem control, scratch and FIFO control state read or drive as zero, `divisor_o` is 1, and the receive queue is empty.
- R2: While line control bit 7 is 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. Such writes neither change interrupt enable nor raise `tx_push_o`.
- R3: While line control bit 7 is 0, a write to offset 0 raises `tx_push_o` for the one cycle after the write edge, with `tx_data_o` equal to the written byte. A read of offset 0 returns the head of the receive queue and removes it.
- R4: A write to offset 2 sets `fifo_en_o` from bit 0, `dma_mode_o` from bit 3 and the trigger select from bits 7:6. A read of offset 2 returns {fifo_en, fifo_en, 2'b00, `int_id_i`}.
- R5: Bit 1 of an offset-2 write raises `rx_flush_o` for exactly one cycle and empties the receive queue. Bit 2 raises `tx_flush_o` for one cycle. Neither bit is stored or read back.
- R6: Modem control bits 0 to 5 drive `dtr_o`, `rts_o`, `out1_o`, `out2_o`, `loopback_o` and `auto_flow_o`, and they read back at offset 4 with bits 7:6 as zero.
- R7: Offsets 5 and 6 are read-only. Writes to them change no register. Offset 5 reads {`line_stat_i`, data-ready}, where data-ready in bit 0 is 1 when the receive queue is non-empty. Offset 6 reads `modem_stat_i`.
- R8: With FIFOs enabled, `rx_trig_o` is 1 when the queue count is at or above the level selected by bits 7:6: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R9: With FIFOs disabled, the queue holds one entry and further pushes are discarded, so `rx_trig_o` rises at a count of 1. A write that changes the enable bit empties the queue.
- R10: With FIFOs enabled, the queue returns up to 16 entries in arrival order. A push while the queue is full is discarded.
- R11: Offset 7 is a scratch byte that reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 3 | Register offset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (pops the queue at offset 0) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current offset |
| int_id_i | input | 4 | Interrupt identification from the interrupt block |
| line_stat_i | input | 7 | Line status bits 7:1 from the serializer |
| modem_stat_i | input | 8 | Modem status byte |
| rx_push_i | input | 1 | Receiver delivers a byte |
| rx_byte_i | input | 8 | Received byte |
| tx_push_o | output | 1 | One-cycle transmit load pulse |
| tx_data_o | output | 8 | Transmit holding byte |
| int_en_o | output | 4 | Interrupt enable bits |
| line_ctl_o | output | 8 | Line control byte |
| divisor_o | output | 16 | Baud divisor |
| dtr_o | output | 1 | DTR pin level |
| rts_o | output | 1 | RTS pin level |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| loopback_o | output | 1 | Loopback mode |
| auto_flow_o | output | 1 | Automatic RTS/CTS flow control |
| fifo_en_o | output | 1 | FIFO enable |
| dma_mode_o | output | 1 | DMA mode select |
| rx_flush_o | output | 1 | Receive flush pulse |
| tx_flush_o | output | 1 | Transmit flush pulse |
| rx_trig_o | output | 1 | Receive fill at or above trigger |
| rx_count_o | output | 5 | Receive queue occupancy |

## Verification
The hardest states to reach from the ports are the upper trigger levels and a full queue. The bench reaches them by issuing single receiver pushes one at a time and checks `rx_trig_o` at the count just below and at each level. It then adds a push past sixteen entries and shows that the discarded byte never appears in the drained order. The claim that the flush bits are never stored is tested by reading offset 2 right after a flush write with an identification code whose bits 1 and 2 are zero. The single-entry disabled mode is reached by changing the enable bit, which must also empty the queue.

// File: rtl/uart_hr_pkg.sv
package uart_hr_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      OFS_DATA    = 3'd0,
      OFS_INTEN   = 3'd1,
      OFS_FIFO    = 3'd2,
      OFS_LINE    = 3'd3,
      OFS_MODEM   = 3'd4,
      OFS_LSTAT   = 3'd5,
      OFS_MSTAT   = 3'd6,
      OFS_SCRATCH = 3'd7
   } reg_ofs_e;

   // Fill level selected by the two trigger bits of FIFO control
   function automatic int unsigned trig_level(input logic [1:0] sel);
      case (sel)
         2'b00:   trig_level = 1;
         2'b01:   trig_level = 4;
         2'b10:   trig_level = 8;
         default: trig_level = 14;
      endcase
   endfunction

endpackage

// File: rtl/uart_hr_csr.sv
module uart_hr_csr
   import uart_hr_pkg::*;
#(
   parameter int                 IE_W    = 4,
   parameter int                 MC_W    = 6,
   parameter logic [2*BYTE_W-1:0] DIV_RST = 16'd1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [2:0]          addr_i,
   input  logic                wr_en_i,
   input  logic [BYTE_W-1:0]   wdata_i,
   output logic [IE_W-1:0]     int_en_o,
   output logic [BYTE_W-1:0]   line_ctl_o,
   output logic [MC_W-1:0]     modem_ctl_o,
   output logic [BYTE_W-1:0]   scratch_o,
   output logic [2*BYTE_W-1:0] divisor_o,
   output logic                fifo_en_o,
   output logic                dma_mode_o,
   output logic [1:0]          trig_sel_o,
   output logic                rx_clear_now_o,
   output logic                rx_flush_o,
   output logic                tx_flush_o,
   output logic                tx_push_o,
   output logic [BYTE_W-1:0]   tx_data_o,
   output logic                dlab_o
);

   localparam int DIV_W = 2 * BYTE_W;

   initial begin
      if (IE_W < 1 || IE_W > BYTE_W) $error("IE_W out of range");
      if (MC_W < 6 || MC_W > BYTE_W) $error("MC_W must cover the six modem bits");
      if (DIV_RST == '0) $error("divisor reset value must be nonzero");
   end

   logic [IE_W-1:0]   ie_q;
   logic [BYTE_W-1:0] lc_q;
   logic [MC_W-1:0]   mc_q;
   logic [BYTE_W-1:0] scr_q;
   logic [DIV_W-1:0]  div_q;
   logic              fen_q, dma_q;
   logic [1:0]        tsel_q;
   logic              rxf_q, txf_q, txp_q;
   logic [BYTE_W-1:0] thr_q;

   logic dlab;
   logic fcr_wr, data_wr, lo_div_wr, hi_div_wr, ie_wr;
   logic en_change, rx_clr, tx_clr;

   assign dlab      = lc_q[BYTE_W-1];
   assign fcr_wr    = wr_en_i && (addr_i == OFS_FIFO);
   assign data_wr   = wr_en_i && (addr_i == OFS_DATA)  && !dlab;
   assign ie_wr     = wr_en_i && (addr_i == OFS_INTEN) && !dlab;
   assign lo_div_wr = wr_en_i && (addr_i == OFS_DATA)  && dlab;
   assign hi_div_wr = wr_en_i && (addr_i == OFS_INTEN) && dlab;
   assign en_change = fcr_wr && (wdata_i[0] != fen_q);
   assign rx_clr    = (fcr_wr && wdata_i[1]) || en_change;
   assign tx_clr    = (fcr_wr && wdata_i[2]) || en_change;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ie_q   <= '0;
         lc_q   <= '0;
         mc_q   <= '0;
         scr_q  <= '0;
         div_q  <= DIV_RST;
         fen_q  <= 1'b0;
         dma_q  <= 1'b0;
         tsel_q <= 2'b00;
         thr_q  <= '0;
      end else begin
         if (ie_wr)     ie_q <= wdata_i[IE_W-1:0];
         if (lo_div_wr) div_q[BYTE_W-1:0] <= wdata_i;
         if (hi_div_wr) div_q[DIV_W-1:BYTE_W] <= wdata_i;
         if (data_wr)   thr_q <= wdata_i;
         if (fcr_wr) begin
            fen_q  <= wdata_i[0];
            dma_q  <= wdata_i[3];
            tsel_q <= wdata_i[7:6];
         end
         if (wr_en_i) begin
            case (addr_i)
               OFS_LINE:    lc_q  <= wdata_i;
               OFS_MODEM:   mc_q  <= wdata_i[MC_W-1:0];
               OFS_SCRATCH: scr_q <= wdata_i;
               default: ;
            endcase
         end
      end
   end

   // Pulses are registered and self-clearing; never held in any register
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rxf_q <= 1'b0;
         txf_q <= 1'b0;
         txp_q <= 1'b0;
      end else begin
         rxf_q <= rx_clr;
         txf_q <= tx_clr;
         txp_q <= data_wr;
      end
   end

   assign int_en_o       = ie_q;
   assign line_ctl_o     = lc_q;
   assign modem_ctl_o    = mc_q;
   assign scratch_o      = scr_q;
   assign divisor_o      = div_q;
   assign fifo_en_o      = fen_q;
   assign dma_mode_o     = dma_q;
   assign trig_sel_o     = tsel_q;
   assign rx_clear_now_o = rx_clr;
   assign rx_flush_o     = rxf_q;
   assign tx_flush_o     = txf_q;
   assign tx_push_o      = txp_q;
   assign tx_data_o      = thr_q;
   assign dlab_o         = dlab;

   // R2
   div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && dlab && (addr_i == OFS_DATA || addr_i == OFS_INTEN)) |=> $stable(div_q));
   // R2
   ie_hold_dlab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && dlab && addr_i == OFS_INTEN) |=> $stable(ie_q));
   // R3
   tx_push_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(txp_q) |-> $past(wr_en_i && addr_i == OFS_DATA && !dlab));
   // R5
   rx_flush_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rxf_q |-> $past(fcr_wr));
   // R7
   ro_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (addr_i == OFS_LSTAT || addr_i == OFS_MSTAT))
         |=> ($stable(lc_q) && $stable(mc_q) && $stable(scr_q) && $stable(ie_q)));

endmodule

// File: rtl/uart_hr_rxfifo.sv
module uart_hr_rxfifo
   import uart_hr_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int DW    = BYTE_W,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             single_i,
   input  logic             push_i,
   input  logic [DW-1:0]    din_i,
   input  logic             pop_i,
   output logic [DW-1:0]    head_o,
   output logic [CNT_W-1:0] count_o
);

   initial begin
      if (DEPTH < 14) $error("DEPTH must reach the highest trigger level");
      if ((1 << PTR_W) != DEPTH) $error("DEPTH must be a power of two");
   end

   logic [DW-1:0]    mem_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cap;
   logic             empty, full, do_pop, do_push;

   assign cap     = single_i ? CNT_W'(1) : CNT_W'(DEPTH);
   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q >= cap);
   assign do_pop  = pop_i && !empty;
   assign do_push = push_i && (!full || do_pop);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else if (clear_i) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (do_push && !clear_i) mem_q[wr_ptr_q] <= din_i;
   end

   assign head_o  = mem_q[rd_ptr_q];
   assign count_o = cnt_q;

   // R10
   count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_W'(DEPTH));
   // R5
   clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (cnt_q == '0));
   // R9
   single_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (single_i && $stable(single_i)) |-> (cnt_q <= CNT_W'(1)));

endmodule

// File: rtl/uart_hr_rxtrig.sv
module uart_hr_rxtrig
   import uart_hr_pkg::*;
#(
   parameter int CNT_W     = 5,
   parameter bit REGISTERED = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             fifo_en_i,
   input  logic [1:0]       sel_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             trig_o
);

   initial begin
      if (CNT_W < 4) $error("CNT_W too narrow for level 14");
   end

   logic [CNT_W-1:0] level;
   logic             hit;

   assign level = fifo_en_i ? CNT_W'(trig_level(sel_i)) : CNT_W'(1);
   assign hit   = (count_i >= level);

   generate
      if (REGISTERED) begin : g_reg
         logic trig_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) trig_q <= 1'b0;
            else         trig_q <= hit;
         end
         assign trig_o = trig_q;
      end else begin : g_comb
         assign trig_o = hit;
         // R8
         trig_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            trig_o |-> (count_i != '0));
         // R9
         trig_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!fifo_en_i && count_i != '0) |-> trig_o);
      end
   endgenerate

endmodule

// File: rtl/uart_hostregs.sv
module uart_hostregs
   import uart_hr_pkg::*;
#(
   parameter int  RX_DEPTH  = 16,
   parameter bit  TRIG_REG  = 1'b0,
   localparam int CNT_W     = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [2:0]        addr_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   input  logic [3:0]        int_id_i,
   input  logic [6:0]        line_stat_i,
   input  logic [7:0]        modem_stat_i,
   input  logic              rx_push_i,
   input  logic [7:0]        rx_byte_i,
   output logic              tx_push_o,
   output logic [7:0]        tx_data_o,
   output logic [3:0]        int_en_o,
   output logic [7:0]        line_ctl_o,
   output logic [15:0]       divisor_o,
   output logic              dtr_o,
   output logic              rts_o,
   output logic              out1_o,
   output logic              out2_o,
   output logic              loopback_o,
   output logic              auto_flow_o,
   output logic              fifo_en_o,
   output logic              dma_mode_o,
   output logic              rx_flush_o,
   output logic              tx_flush_o,
   output logic              rx_trig_o,
   output logic [CNT_W-1:0]  rx_count_o
);

   localparam int IE_W = 4;
   localparam int MC_W = 6;

   logic [IE_W-1:0] ie;
   logic [7:0]      lc, scr, head;
   logic [MC_W-1:0] mc;
   logic [15:0]     div;
   logic            fen, dma, clr_now, dlab;
   logic [1:0]      tsel;
   logic            pop;
   logic [CNT_W-1:0] cnt;

   uart_hr_csr #(.IE_W(IE_W), .MC_W(MC_W), .DIV_RST(16'd1)) csr_i (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .addr_i         (addr_i),
      .wr_en_i        (wr_en_i),
      .wdata_i        (wdata_i),
      .int_en_o       (ie),
      .line_ctl_o     (lc),
      .modem_ctl_o    (mc),
      .scratch_o      (scr),
      .divisor_o      (div),
      .fifo_en_o      (fen),
      .dma_mode_o     (dma),
      .trig_sel_o     (tsel),
      .rx_clear_now_o (clr_now),
      .rx_flush_o     (rx_flush_o),
      .tx_flush_o     (tx_flush_o),
      .tx_push_o      (tx_push_o),
      .tx_data_o      (tx_data_o),
      .dlab_o         (dlab)
   );

   assign pop = rd_en_i && (addr_i == OFS_DATA) && !dlab;

   uart_hr_rxfifo #(.DEPTH(RX_DEPTH), .DW(8)) rxq_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (clr_now),
      .single_i (!fen),
      .push_i   (rx_push_i),
      .din_i    (rx_byte_i),
      .pop_i    (pop),
      .head_o   (head),
      .count_o  (cnt)
   );

   uart_hr_rxtrig #(.CNT_W(CNT_W), .REGISTERED(TRIG_REG)) trig_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fifo_en_i (fen),
      .sel_i     (tsel),
      .count_i   (cnt),
      .trig_o    (rx_trig_o)
   );

   always_comb begin
      case (addr_i)
         OFS_DATA:    rdata_o = dlab ? div[7:0]  : head;
         OFS_INTEN:   rdata_o = dlab ? div[15:8] : {{(8-IE_W){1'b0}}, ie};
         OFS_FIFO:    rdata_o = {fen, fen, 2'b00, int_id_i};
         OFS_LINE:    rdata_o = lc;
         OFS_MODEM:   rdata_o = {{(8-MC_W){1'b0}}, mc};
         OFS_LSTAT:   rdata_o = {line_stat_i, (cnt != '0)};
         OFS_MSTAT:   rdata_o = modem_stat_i;
         default:     rdata_o = scr;
      endcase
   end

   assign int_en_o    = ie;
   assign line_ctl_o  = lc;
   assign divisor_o   = div;
   assign dtr_o       = mc[0];
   assign rts_o       = mc[1];
   assign out1_o      = mc[2];
   assign out2_o      = mc[3];
   assign loopback_o  = mc[4];
   assign auto_flow_o = mc[5];
   assign fifo_en_o   = fen;
   assign dma_mode_o  = dma;
   assign rx_count_o  = cnt;

   // R3
   pop_drains_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop && !rx_push_i && !clr_now && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
   // R1
   divisor_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (div == 16'd1));

endmodule

// File: tb/uart_hostregs_tb_top.sv
`timescale 1ns/1ps
module uart_hostregs_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [3:0] int_id = 4'h1;
   logic [6:0] lstat = '0;
   logic [7:0] mstat = '0;
   logic       rx_push = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       tx_push, dtr, rts, out1, out2, loopb, aflow, fen, dma, rxf, txf, trig;
   logic [7:0] tx_data, lctl;
   logic [3:0] ien;
   logic [15:0] div;
   logic [4:0] cnt;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   uart_hostregs dut_i (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .wdata_i(wdata), .rdata_o(rdata), .int_id_i(int_id), .line_stat_i(lstat),
      .modem_stat_i(mstat), .rx_push_i(rx_push), .rx_byte_i(rx_byte),
      .tx_push_o(tx_push), .tx_data_o(tx_data), .int_en_o(ien), .line_ctl_o(lctl),
      .divisor_o(div), .dtr_o(dtr), .rts_o(rts), .out1_o(out1), .out2_o(out2),
      .loopback_o(loopb), .auto_flow_o(aflow), .fifo_en_o(fen), .dma_mode_o(dma),
      .rx_flush_o(rxf), .tx_flush_o(txf), .rx_trig_o(trig), .rx_count_o(cnt)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #2 d = rdata;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      rx_push = 1'b1; rx_byte = b;
      @(posedge clk); #1;
      rx_push = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      rd(3'd1, v); check("R1 inten", v, 8'h00);
      rd(3'd3, v); check("R1 linectl", v, 8'h00);
      rd(3'd4, v); check("R1 modemctl", v, 8'h00);
      rd(3'd7, v); check("R1 scratch", v, 8'h00);
      check("R1 divisor", div, 16'd1);
      check("R1 fifo_en", fen, 1'b0);
      check("R1 count", cnt, 5'd0);
   endtask

   task automatic t_scratch;
      logic [7:0] v;
      wr(3'd7, 8'hA5); rd(3'd7, v); check("R11 scratch A5", v, 8'hA5);
      wr(3'd7, 8'h5A); rd(3'd7, v); check("R11 scratch 5A", v, 8'h5A);
   endtask

   task automatic t_dlab;
      logic [7:0] v;
      wr(3'd1, 8'h05);
      wr(3'd3, 8'h83);
      wr(3'd0, 8'h34);
      check("R2 no tx push", tx_push, 1'b0);
      wr(3'd1, 8'h12);
      check("R2 divisor", div, 16'h1234);
      rd(3'd0, v); check("R2 div lo read", v, 8'h34);
      rd(3'd1, v); check("R2 div hi read", v, 8'h12);
      wr(3'd3, 8'h03);
      rd(3'd1, v); check("R2 inten kept", v, 8'h05);
      check("R2 int_en pins", ien, 4'h5);
      rd(3'd3, v); check("R2 linectl", v, 8'h03);
   endtask

   task automatic t_tx;
      wr(3'd0, 8'h5C);
      check("R3 tx push", tx_push, 1'b1);
      check("R3 tx data", tx_data, 8'h5C);
      @(posedge clk); #1;
      check("R3 tx push ends", tx_push, 1'b0);
   endtask

   task automatic t_modem;
      logic [7:0] v;
      wr(3'd4, 8'hD5);
      check("R6 pins 15", {aflow, loopb, out2, out1, rts, dtr}, 6'h15);
      rd(3'd4, v); check("R6 read 15", v, 8'h15);
      wr(3'd4, 8'h2A);
      check("R6 pins 2A", {aflow, loopb, out2, out1, rts, dtr}, 6'h2A);
   endtask

   task automatic t_readonly;
      logic [7:0] v;
      lstat = 7'h30; mstat = 8'hB3;
      wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
      rd(3'd5, v); check("R7 lstat", v, 8'h60);
      rd(3'd6, v); check("R7 mstat", v, 8'hB3);
      rd(3'd3, v); check("R7 linectl kept", v, 8'h03);
      rd(3'd4, v); check("R7 modemctl kept", v, 8'h2A);
      rd(3'd7, v); check("R7 scratch kept", v, 8'h5A);
   endtask

   task automatic t_fifo_order;
      logic [7:0] v;
      wr(3'd2, 8'h01);
      check("R4 fifo_en", fen, 1'b1);
      rd(3'd2, v); check("R4 iir read", v, 8'hC1);
      for (int i = 0; i < 16; i++) push(8'(i * 3 + 1));
      check("R10 full count", cnt, 5'd16);
      push(8'hEE);
      check("R10 overflow drop", cnt, 5'd16);
      rd(3'd5, v); check("R7 data ready", v[0], 1'b1);
      for (int i = 0; i < 16; i++) begin
         rd(3'd0, v); check("R10 order", v, 8'(i * 3 + 1));
      end
      check("R10 drained", cnt, 5'd0);
      rd(3'd5, v); check("R7 not ready", v[0], 1'b0);
   endtask

   task automatic t_trigger;
      logic [7:0] v;
      int lv [4] = '{1, 4, 8, 14};
      for (int s = 0; s < 4; s++) begin
         wr(3'd2, 8'(8'h01 | (s << 6)));
         for (int k = 0; k < lv[s] - 1; k++) push(8'(k));
         check("R8 below level", trig, 1'b0);
         push(8'hAA);
         check("R8 at level", trig, 1'b1);
         wr(3'd2, 8'(8'h03 | (s << 6)));
         check("R5 rx flush pulse", rxf, 1'b1);
         check("R5 flushed", cnt, 5'd0);
         rd(3'd2, v);
         check("R5 flush not stored", v, 8'hC1);
         check("R5 pulse ended", rxf, 1'b0);
      end
      wr(3'd2, 8'h05);
      check("R5 tx flush pulse", txf, 1'b1);
      check("R5 no rx flush", rxf, 1'b0);
      @(posedge clk); #1;
      check("R5 tx flush ends", txf, 1'b0);
      wr(3'd2, 8'h09);
      check("R4 dma mode", dma, 1'b1);
   endtask

   task automatic t_disabled;
      logic [7:0] v;
      push(8'h11); push(8'h22);
      wr(3'd2, 8'h00);
      check("R9 enable change clears", cnt, 5'd0);
      rd(3'd2, v); check("R4 iir disabled", v, 8'h01);
      push(8'hA1); push(8'hB2);
      check("R9 single count", cnt, 5'd1);
      check("R9 trig at one", trig, 1'b1);
      rd(3'd0, v); check("R9 first kept", v, 8'hA1);
      check("R9 empty", cnt, 5'd0);
      check("R9 trig low", trig, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_scratch();
      t_dlab();
      t_tx();
      t_modem();
      t_readonly();
      t_fifo_order();
      t_trigger();
      t_disabled();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule